// File: doc/BRIEF.md
# Eight-bit ALU with flag register

This block performs one 8-bit arithmetic, logic, shift or flag-bit operation for each request it accepts. A request carries an operation code, two operands and a flag index. The block computes the result and the new flag byte in one combinational pass. The flag register is internal and persistent, so the carry that a request consumes is the carry left by the request accepted before it. Each operation writes only its own subset of the half-carry (H), sign (S), overflow (V), negative (N), zero (Z) and carry (C) flags, chosen by a per-operation mask. Every other flag bit keeps its value.

Requests enter through a valid/ready handshake, and results leave through another. A request is accepted in any cycle in which `in_valid` and `in_ready` are both high. Its result and flag byte appear on the output one cycle later, with `out_valid` high. While `out_valid` is high and `out_ready` is low, the output holds steady and `in_ready` is low, so back-pressure stalls the input. The output stage is a single register. When the consumer drains the old result, a new request can be accepted in the same cycle.

Top module: `alu8_flagged`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. Each accepted request gives exactly one result, with `out_valid` high, in the next cycle. While a result is stalled (`out_valid` high, `out_ready` low), `out_result`, `out_sreg` and the internal flags do not change.
- R2: The flag byte holds, from bit 7 down to bit 0: interrupt-enable I, transfer T, H, S, V, N, Z, C. Reset clears it to 0x00. `out_sreg` shows the flag byte as it stands after the request that produced `out_result`.
- R3: Add (code 0x00) returns a+b. Add-with-carry (0x01) returns a+b+C. Both write H (carry out of bit 3), V (signed overflow), N (bit 7 of the result), Z (result is zero) and C (carry out of bit 7).
- R4: Subtract (0x02) returns a-b. Subtract-with-carry (0x03) returns a-b-C. Both write H and C as borrow flags (borrow into bit 4 and out of bit 7), and also write V, N and Z.
- R5: AND (0x04), OR (0x05) and XOR (0x06) write N and Z, clear V to 0, and leave H and C unchanged.
- R6: One's complement (0x07) returns 0xFF-a, sets C to 1, clears V and writes N and Z. Negate (0x08) returns 0x00-a and writes H, V, N, Z and C as the subtraction 0-a does. Both leave H or C unchanged only where these rules do not name them; complement keeps H.
- R7: Increment (0x09) and decrement (0x0A) write N and Z. V is set only when the result is 0x80 (increment) or 0x7F (decrement). C and H keep their values.
- R8: Shift left (0x0B) inserts 0 at bit 0 and moves bit 7 into C. Shift right (0x0C) inserts 0 at bit 7 and moves bit 0 into C. Arithmetic shift right (0x0F) keeps bit 7 and moves bit 0 into C. Each writes N and Z, sets V to N XOR C, and keeps H.
- R9: Rotate left (0x0D) shifts the old C into bit 0 and bit 7 into C. Rotate right (0x0E) shifts the old C into bit 7 and bit 0 into C. V, N and Z follow the R8 rules.
- R10: Swap (0x10) exchanges the two 4-bit halves of a and leaves all eight flag bits unchanged.
- R11: Flag-set (0x11) and flag-clear (0x12) write 1 or 0 to the single flag bit selected by `in_bit` (0 = C ... 7 = I) and return 0x00. Bits I and T change only through these two codes.
- R12: Whenever an operation writes N or V, it also writes S, with S equal to N XOR V of the new flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted this cycle |
| in_op | input | 5 | Operation code |
| in_a | input | 8 | First operand |
| in_b | input | 8 | Second operand (two-operand codes only) |
| in_bit | input | 3 | Flag index for flag-set and flag-clear |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Operation result |
| out_sreg | output | 8 | Flag byte after the operation |

## Verification
The case of interest is a carry-consuming request that is accepted in the same cycle in which the consumer drains the result that produced that carry. The bench provokes it with an add that overflows, followed directly by add-with-carry, rotates and subtract-with-carry. A repeating stall pattern on `out_ready` keeps shifting where drains and accepts coincide. A scoreboard model carries its own flag byte in acceptance order and compares every drained result and flag byte. At every sample point the bench also checks that a stalled output holds its value and that `in_ready` follows the drain rule.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW    = 8;
  localparam int NW    = DW / 2;
  localparam int SW    = 8;
  localparam int BITW  = $clog2(SW);
  localparam int OPW   = 5;

  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;
  localparam int F_T = 6;
  localparam int F_I = 7;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'h00,
    OP_ADC  = 5'h01,
    OP_SUB  = 5'h02,
    OP_SBC  = 5'h03,
    OP_AND  = 5'h04,
    OP_OR   = 5'h05,
    OP_XOR  = 5'h06,
    OP_COM  = 5'h07,
    OP_NEG  = 5'h08,
    OP_INC  = 5'h09,
    OP_DEC  = 5'h0A,
    OP_LSL  = 5'h0B,
    OP_LSR  = 5'h0C,
    OP_ROL  = 5'h0D,
    OP_ROR  = 5'h0E,
    OP_ASR  = 5'h0F,
    OP_SWAP = 5'h10,
    OP_FSET = 5'h11,
    OP_FCLR = 5'h12
  } op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  input  logic          cin,
  input  logic          do_sub,
  output logic [DW-1:0] sum,
  output logic          c_out,
  output logic          h_out,
  output logic          v_out
);
  localparam int NW = DW / 2;

  logic [DW:0] full;
  logic [NW:0] low;

  always_comb begin
    if (do_sub) begin
      full = {1'b0, opa} - {1'b0, opb} - {{DW{1'b0}}, cin};
      low  = {1'b0, opa[NW-1:0]} - {1'b0, opb[NW-1:0]} - {{NW{1'b0}}, cin};
    end else begin
      full = {1'b0, opa} + {1'b0, opb} + {{DW{1'b0}}, cin};
      low  = {1'b0, opa[NW-1:0]} + {1'b0, opb[NW-1:0]} + {{NW{1'b0}}, cin};
    end
    sum   = full[DW-1:0];
    c_out = full[DW];
    h_out = low[NW];
    if (do_sub)
      v_out = (opa[DW-1] != opb[DW-1]) && (full[DW-1] != opa[DW-1]);
    else
      v_out = (opa[DW-1] == opb[DW-1]) && (full[DW-1] != opa[DW-1]);
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] r,
  output logic          c_shift
);
  localparam int NW = DW / 2;

  always_comb begin
    r       = '0;
    c_shift = 1'b0;
    case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      OP_COM:  r = ~a;
      OP_LSL:  begin r = {a[DW-2:0], 1'b0};      c_shift = a[DW-1]; end
      OP_LSR:  begin r = {1'b0, a[DW-1:1]};      c_shift = a[0];    end
      OP_ROL:  begin r = {a[DW-2:0], cin};       c_shift = a[DW-1]; end
      OP_ROR:  begin r = {cin, a[DW-1:1]};       c_shift = a[0];    end
      OP_ASR:  begin r = {a[DW-1], a[DW-1:1]};   c_shift = a[0];    end
      OP_SWAP: r = {a[NW-1:0], a[DW-1:NW]};
      default: r = '0;
    endcase
  end
endmodule

// File: rtl/alu8_flagmix.sv
module alu8_flagmix
  import alu8_pkg::*;
#(
  parameter int DW = 8,
  parameter int SW = 8
) (
  input  op_e                   op,
  input  logic [$clog2(SW)-1:0] idx,
  input  logic [SW-1:0]         flags_q,
  input  logic [DW-1:0]         res,
  input  logic                  ar_c,
  input  logic                  ar_h,
  input  logic                  ar_v,
  input  logic                  sh_c,
  output logic [SW-1:0]         flags_d
);
  logic [SW-1:0] mask;
  logic [SW-1:0] calc;
  logic          n_new;
  logic          z_new;
  logic          v_new;
  logic          c_new;

  assign n_new = res[DW-1];
  assign z_new = (res == '0);

  always_comb begin
    mask  = '0;
    v_new = 1'b0;
    c_new = 1'b0;
    calc  = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        mask  = SW'((1 << F_H) | (1 << F_S) | (1 << F_V) | (1 << F_N) | (1 << F_Z) | (1 << F_C));
        v_new = ar_v;
        c_new = ar_c;
      end
      OP_INC, OP_DEC: begin
        mask  = SW'((1 << F_S) | (1 << F_V) | (1 << F_N) | (1 << F_Z));
        v_new = ar_v;
      end
      OP_AND, OP_OR, OP_XOR: begin
        mask  = SW'((1 << F_S) | (1 << F_V) | (1 << F_N) | (1 << F_Z));
      end
      OP_COM: begin
        mask  = SW'((1 << F_S) | (1 << F_V) | (1 << F_N) | (1 << F_Z) | (1 << F_C));
        c_new = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        mask  = SW'((1 << F_S) | (1 << F_V) | (1 << F_N) | (1 << F_Z) | (1 << F_C));
        c_new = sh_c;
        v_new = n_new ^ sh_c;
      end
      OP_FSET, OP_FCLR: begin
        mask  = SW'(1) << idx;
      end
      default: mask = '0;
    endcase
    if (op == OP_FSET)
      calc = '1;
    else if (op == OP_FCLR)
      calc = '0;
    else begin
      calc[F_H] = ar_h;
      calc[F_S] = n_new ^ v_new;
      calc[F_V] = v_new;
      calc[F_N] = n_new;
      calc[F_Z] = z_new;
      calc[F_C] = c_new;
    end
  end

  for (genvar g = 0; g < SW; g++) begin : g_merge
    assign flags_d[g] = mask[g] ? calc[g] : flags_q[g];
  end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OPW-1:0]  in_op,
  input  logic [DW-1:0]   in_a,
  input  logic [DW-1:0]   in_b,
  input  logic [BITW-1:0] in_bit,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [DW-1:0]   out_result,
  output logic [SW-1:0]   out_sreg
);
  op_e           op;
  logic          accept;
  logic [SW-1:0] status_q;
  logic [SW-1:0] status_d;
  logic [DW-1:0] res_q;
  logic [SW-1:0] sreg_q;
  logic          ov_q;

  logic [DW-1:0] as_a;
  logic [DW-1:0] as_b;
  logic          as_cin;
  logic          as_sub;
  logic [DW-1:0] as_sum;
  logic          as_c;
  logic          as_h;
  logic          as_v;
  logic [DW-1:0] bo_r;
  logic          bo_c;
  logic          use_arith;
  logic [DW-1:0] res_d;

  assign op       = op_e'(in_op);
  assign in_ready = !ov_q || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    as_a      = in_a;
    as_b      = in_b;
    as_cin    = 1'b0;
    as_sub    = 1'b0;
    use_arith = 1'b1;
    case (op)
      OP_ADD: ;
      OP_ADC: as_cin = status_q[F_C];
      OP_SUB: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = status_q[F_C]; end
      OP_NEG: begin as_sub = 1'b1; as_a = '0; as_b = in_a; end
      OP_INC: as_b = DW'(1);
      OP_DEC: begin as_sub = 1'b1; as_b = DW'(1); end
      default: use_arith = 1'b0;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .opa    (as_a),
    .opb    (as_b),
    .cin    (as_cin),
    .do_sub (as_sub),
    .sum    (as_sum),
    .c_out  (as_c),
    .h_out  (as_h),
    .v_out  (as_v)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op      (op),
    .a       (in_a),
    .b       (in_b),
    .cin     (status_q[F_C]),
    .r       (bo_r),
    .c_shift (bo_c)
  );

  assign res_d = use_arith ? as_sum : bo_r;

  alu8_flagmix #(.DW(DW), .SW(SW)) u_flagmix (
    .op      (op),
    .idx     (in_bit),
    .flags_q (status_q),
    .res     (res_d),
    .ar_c    (as_c),
    .ar_h    (as_h),
    .ar_v    (as_v),
    .sh_c    (bo_c),
    .flags_d (status_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      res_q    <= '0;
      sreg_q   <= '0;
      ov_q     <= 1'b0;
    end else if (accept) begin
      status_q <= status_d;
      res_q    <= res_d;
      sreg_q   <= status_d;
      ov_q     <= 1'b1;
    end else if (out_ready) begin
      ov_q     <= 1'b0;
    end
  end

  assign out_valid  = ov_q;
  assign out_result = res_q;
  assign out_sreg   = sreg_q;
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk
  import alu8_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [OPW-1:0] in_op,
  input logic           out_valid,
  input logic           out_ready,
  input logic [DW-1:0]  out_result,
  input logic [SW-1:0]  out_sreg,
  input logic [SW-1:0]  status_q
);
  logic acc;
  assign acc = in_valid && in_ready;

  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_sreg));

  a_r1_flags_frozen_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(status_q));

  a_r2_out_shows_flags: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid && (out_sreg == status_q));

  a_r5_logic_clears_v: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_AND || in_op == OP_OR || in_op == OP_XOR) |=> !status_q[F_V]);

  a_r7_incdec_keep_c: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (in_op == OP_INC || in_op == OP_DEC)
      |=> status_q[F_C] == $past(status_q[F_C]) && status_q[F_H] == $past(status_q[F_H]));

  a_r10_swap_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == OP_SWAP |=> status_q == $past(status_q));

  a_r11_it_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op != OP_FSET && in_op != OP_FCLR
      |=> status_q[F_I:F_T] == $past(status_q[F_I:F_T]));

  a_r12_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op <= OP_ASR |=> status_q[F_S] == (status_q[F_N] ^ status_q[F_V]));
endmodule

bind alu8_flagged alu8_flagged_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_sreg   (out_sreg),
  .status_q   (status_q)
);

// File: tb/alu8_flagged_tb.sv
`timescale 1ns/1ps
module alu8_flagged_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0;
  logic [7:0] in_b = '0;
  logic [2:0] in_bit = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_result;
  logic [7:0] out_sreg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] r;
    logic [7:0] f;
    string      tag;
  } exp_t;
  exp_t sb[$];
  logic [7:0] model_f = 8'h00;

  always #2.5 clk = ~clk;

  alu8_flagged dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_sreg(out_sreg)
  );

  function automatic int sgn(input int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // Reference: flag byte I T H S V N Z C from bit 7 to bit 0
  function automatic logic [15:0] ref_op(input logic [4:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [2:0] k,
                                         input logic [7:0] f);
    int ai = a, bi = b, ci = f[0], t, x, y, cin, sv;
    logic [7:0] r = 8'h00;
    logic h = f[5], v = f[3], c = f[0], n, z;
    bit wh = 0, wv = 0, wc = 0, wnz = 0;
    logic [7:0] fo = f;
    case (op)
      5'h00, 5'h01: begin
        cin = (op == 5'h01) ? ci : 0;
        t = ai + bi + cin; r = t[7:0]; c = (t > 255);
        h = ((ai % 16) + (bi % 16) + cin) > 15;
        sv = sgn(ai) + sgn(bi) + cin; v = (sv > 127) || (sv < -128);
        wh = 1; wv = 1; wc = 1; wnz = 1;
      end
      5'h02, 5'h03, 5'h08: begin
        if (op == 5'h08) begin x = 0; y = ai; cin = 0; end
        else begin x = ai; y = bi; cin = (op == 5'h03) ? ci : 0; end
        t = x - y - cin; r = t[7:0]; c = (x < y + cin);
        h = (x % 16) < ((y % 16) + cin);
        sv = sgn(x) - sgn(y) - cin; v = (sv > 127) || (sv < -128);
        wh = 1; wv = 1; wc = 1; wnz = 1;
      end
      5'h04: begin r = a & b; v = 0; wv = 1; wnz = 1; end
      5'h05: begin r = a | b; v = 0; wv = 1; wnz = 1; end
      5'h06: begin r = a ^ b; v = 0; wv = 1; wnz = 1; end
      5'h07: begin t = 255 - ai; r = t[7:0]; c = 1; v = 0; wv = 1; wc = 1; wnz = 1; end
      5'h09: begin t = ai + 1; r = t[7:0]; v = (ai == 127); wv = 1; wnz = 1; end
      5'h0A: begin t = ai + 255; r = t[7:0]; v = (ai == 128); wv = 1; wnz = 1; end
      5'h0B: begin t = ai * 2; r = t[7:0]; c = a[7]; wc = 1; wnz = 1; end
      5'h0C: begin t = ai / 2; r = t[7:0]; c = a[0]; wc = 1; wnz = 1; end
      5'h0D: begin t = ai * 2 + ci; r = t[7:0]; c = a[7]; wc = 1; wnz = 1; end
      5'h0E: begin t = ai / 2 + ci * 128; r = t[7:0]; c = a[0]; wc = 1; wnz = 1; end
      5'h0F: begin t = ai / 2 + (ai & 128); r = t[7:0]; c = a[0]; wc = 1; wnz = 1; end
      5'h10: begin t = (ai % 16) * 16 + ai / 16; r = t[7:0]; end
      5'h11: fo[k] = 1'b1;
      5'h12: fo[k] = 1'b0;
      default: ;
    endcase
    n = r[7]; z = (r == 8'h00);
    if (op >= 5'h0B && op <= 5'h0F) begin v = n ^ c; wv = 1; end
    if (wnz) begin fo[2] = n; fo[1] = z; end
    if (wv) begin fo[3] = v; fo[4] = n ^ v; end
    if (wc) fo[0] = c;
    if (wh) fo[5] = h;
    return {r, fo};
  endfunction

  task automatic issue(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [2:0] k, input string tag);
    logic [15:0] e;
    exp_t it;
    bit took;
    e = ref_op(op, a, b, k, model_f);
    model_f = e[7:0];
    it.r = e[15:8]; it.f = e[7:0]; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_bit = k;
    forever begin
      #1; took = in_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk); #1;
    end
  endtask

  // out_ready stall pattern, changed just after each falling edge
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk); #1;
      cyc++;
      out_ready = (cyc % 5 != 2) && (cyc % 7 != 4);
    end
  end

  // Monitor / scoreboard, samples 0.5 ns before each rising edge
  initial begin
    bit prev_stall = 0;
    logic [7:0] pr = '0, pf = '0;
    exp_t it;
    @(posedge rst_n);
    forever begin
      @(negedge clk); #2;
      checks++;
      if (in_ready !== (!out_valid || out_ready)) begin
        failures++;
        $display("FAIL R1 in_ready: actual %b expected %b", in_ready, (!out_valid || out_ready));
      end
      if (prev_stall) begin
        checks++;
        if (out_valid !== 1'b1 || out_result !== pr || out_sreg !== pf) begin
          failures++;
          $display("FAIL R1 stall hold: actual v=%b r=%h f=%h expected v=1 r=%h f=%h",
                   out_valid, out_result, out_sreg, pr, pf);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R1 unexpected result: actual r=%h expected none", out_result);
        end else begin
          it = sb.pop_front();
          if (out_result !== it.r || out_sreg !== it.f) begin
            failures++;
            $display("FAIL %s: actual r=%h f=%h expected r=%h f=%h",
                     it.tag, out_result, out_sreg, it.r, it.f);
          end
        end
      end
      prev_stall = out_valid && !out_ready;
      pr = out_result; pf = out_sreg;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 50000);
    failures++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    #1;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      failures++;
      $display("FAIL R2 reset: actual v=%b rdy=%b expected v=0 rdy=1", out_valid, in_ready);
    end
    issue(5'h10, 8'h3C, 8'h00, 3'd0, "R2 reset flags via R10 swap");
    issue(5'h11, 8'h00, 8'h00, 3'd7, "R11 set I");
    issue(5'h11, 8'h00, 8'h00, 3'd6, "R11 set T");
    issue(5'h00, 8'h7F, 8'h01, 3'd0, "R3 add overflow R12");
    issue(5'h00, 8'hFF, 8'h01, 3'd0, "R3 add carry zero");
    issue(5'h01, 8'h10, 8'h20, 3'd0, "R3 adc carry in");
    issue(5'h01, 8'h80, 8'h80, 3'd0, "R3 adc wrap");
    issue(5'h02, 8'h00, 8'h01, 3'd0, "R4 sub borrow");
    issue(5'h03, 8'h50, 8'h10, 3'd0, "R4 sbc borrow in");
    issue(5'h03, 8'h80, 8'h01, 3'd0, "R4 sbc signed overflow");
    issue(5'h11, 8'h00, 8'h00, 3'd3, "R11 set V");
    issue(5'h11, 8'h00, 8'h00, 3'd0, "R11 set C");
    issue(5'h04, 8'hF0, 8'h0F, 3'd0, "R5 and zero clears V keeps C");
    issue(5'h05, 8'h80, 8'h01, 3'd0, "R5 or negative");
    issue(5'h06, 8'hAA, 8'hAA, 3'd0, "R5 xor zero");
    issue(5'h07, 8'h55, 8'h00, 3'd0, "R6 complement");
    issue(5'h08, 8'h80, 8'h00, 3'd0, "R6 negate 0x80");
    issue(5'h08, 8'h00, 8'h00, 3'd0, "R6 negate zero");
    issue(5'h08, 8'h01, 8'h00, 3'd0, "R6 negate one");
    issue(5'h12, 8'h00, 8'h00, 3'd0, "R11 clear C");
    issue(5'h09, 8'h7F, 8'h00, 3'd0, "R7 inc to 0x80");
    issue(5'h11, 8'h00, 8'h00, 3'd0, "R11 set C before inc");
    issue(5'h09, 8'hFF, 8'h00, 3'd0, "R7 inc wrap keeps C");
    issue(5'h0A, 8'h80, 8'h00, 3'd0, "R7 dec to 0x7F");
    issue(5'h0A, 8'h00, 8'h00, 3'd0, "R7 dec wrap");
    issue(5'h0B, 8'h81, 8'h00, 3'd0, "R8 shift left");
    issue(5'h0C, 8'h01, 8'h00, 3'd0, "R8 shift right zero");
    issue(5'h0F, 8'h81, 8'h00, 3'd0, "R8 arith shift right");
    issue(5'h0D, 8'h80, 8'h00, 3'd0, "R9 rotate left");
    issue(5'h0D, 8'h40, 8'h00, 3'd0, "R9 rotate left carry in");
    issue(5'h0E, 8'h01, 8'h00, 3'd0, "R9 rotate right");
    issue(5'h0E, 8'h02, 8'h00, 3'd0, "R9 rotate right carry in");
    issue(5'h10, 8'hA5, 8'h00, 3'd0, "R10 swap keeps flags");
    issue(5'h12, 8'h00, 8'h00, 3'd7, "R11 clear I");
    issue(5'h00, 8'h08, 8'h08, 3'd0, "R3 half carry R12");
    issue(5'h04, 8'hFF, 8'h80, 3'd0, "R12 S after logic");
    @(negedge clk); #1 in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule